// File: doc/BRIEF.md
# Asymmetric Attack/Release Debouncer

This block cleans a single contact input whose settling time differs for its two edges. It samples the input on a rate tick and changes its output only after four samples in a row disagree with the current output. A sample that agrees with the output discards the partial run. The output level itself selects the rate. While the output rests in one level, the block samples on every clock cycle (the fast rate). While it rests in the other level, it samples once every `div_n` clock cycles (the slow rate). Attack and release delays can therefore be set on their own.

With `swap_rates` low, a rising edge is qualified at the fast rate and a falling edge at the slow rate, which gives fast attack with slow release. Setting `swap_rates` exchanges the two rates and gives slow attack with fast release. The selected sampling strobe is driven out on `rate_tick`, so neighbouring channels that need the same asymmetric timing can share it. The raw input first passes through a synchronizer. The divider count restarts whenever the output flips, so the first slow sample after a flip is never a shortened one.

Top module: `asym_debounce`

## Requirements
- R1: While `rst_n` is low, `clean_out` is 0, the run count and divider count are cleared, and the synchronizer holds 0; a run of samples started before reset does not count afterwards.
- R2: `raw_in` passes through SYNC_STAGES (default 2) flip-flops before it is sampled, so with the fast rate active a clean edge on `raw_in` appears on `clean_out` exactly SYNC_STAGES+4 clock edges later.
- R3: `clean_out` flips on the rate tick that carries the fourth consecutive sample differing from it; a tick whose sample equals `clean_out` restarts the run, and input activity between ticks has no effect.
- R4: The fast rate produces a sampling tick on every clock cycle.
- R5: The slow rate produces one tick every `div_n` clock cycles; `div_n` equal to 0 or 1 gives a tick on every cycle.
- R6: With `swap_rates`=0 the fast rate is used while `clean_out`=0 and the slow rate while `clean_out`=1; with `swap_rates`=1 the choice is reversed.
- R7: The divider count restarts on the edge at which `clean_out` flips, so that after a flip into the slow rate the first tick comes exactly `div_n` edges later and a slow release takes exactly 4·`div_n` edges.
- R8: `rate_tick` is high in exactly the cycles in which the integrator takes a sample, and `clean_out` never changes after a cycle in which `rate_tick` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the fast rate equals its frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Bouncing contact level |
| div_n | input | DIV_W (8) | Slow-rate divisor N; 0 and 1 mean no division |
| swap_rates | input | 1 | 0: fast attack, slow release; 1: slow attack, fast release |
| clean_out | output | 1 | Debounced level, 0 after reset |
| rate_tick | output | 1 | Sampling strobe currently in use, for sharing with other channels |

## Verification
The spacing properties assume that `div_n` and `swap_rates` are quasi-static: each check that depends on them is released in any cycle where either input has just changed. The stimulus changes them only at segment boundaries, and the random bursts run with both held constant. `raw_in` is taken to be asynchronous and may toggle on any cycle, including between slow ticks. The stimulus relies on this to show that glitches between ticks are ignored.

// File: rtl/asym_db_pkg.sv
package asym_db_pkg;

  // Slow tick is due when the elapsed count has reached the divisor minus one.
  // Divisors of 0 or 1 request no division at all.
  function automatic logic div_due(input int unsigned count, input int unsigned divisor);
    if (divisor <= 1) return 1'b1;
    return (count + 1) >= divisor;
  endfunction

  // The slow rate is in use when the output level differs from the swap bit.
  function automatic logic pick_slow(input logic level, input logic swap);
    return level ^ swap;
  endfunction

endpackage

// File: rtl/asym_db_sync.sv
module asym_db_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], d} ;
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/asym_db_divider.sv
module asym_db_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  import asym_db_pkg::*;

  logic [DIV_W-1:0] count;

  assign tick = run && div_due(32'(count), 32'(div_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (!run || restart || tick) count <= '0;
    else                             count <= count + 1'b1;
  end
endmodule

// File: rtl/asym_db_integrator.sv
module asym_db_integrator #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic din,
  output logic level,
  output logic flip
);
  localparam int RUN_W = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
  localparam logic [RUN_W-1:0] LAST = RUN_W'(SAMPLES - 1);

  logic [RUN_W-1:0] run_len;
  logic             differs;

  assign differs = din != level;
  assign flip    = sample_en && differs && (run_len == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      level   <= 1'b0;
    end else if (sample_en) begin
      if (!differs || flip) run_len <= '0;
      else                  run_len <= run_len + 1'b1;
      if (flip) level <= ~level;
    end
  end
endmodule

// File: rtl/asym_debounce.sv
module asym_debounce #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLES     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_in,
  input  logic [DIV_W-1:0] div_n,
  input  logic             swap_rates,
  output logic             clean_out,
  output logic             rate_tick
);
  import asym_db_pkg::*;

  logic sampled;
  logic use_slow;
  logic slow_tick;
  logic flip_ev;

  asym_db_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sampled)
  );

  assign use_slow  = pick_slow(clean_out, swap_rates);
  assign rate_tick = use_slow ? slow_tick : 1'b1;

  asym_db_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(use_slow), .restart(flip_ev),
    .div_n(div_n), .tick(slow_tick)
  );

  asym_db_integrator #(.SAMPLES(SAMPLES)) u_integ (
    .clk(clk), .rst_n(rst_n), .sample_en(rate_tick), .din(sampled),
    .level(clean_out), .flip(flip_ev)
  );
endmodule

// File: rtl/asym_debounce_chk.sv
module asym_debounce_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             swap_rates,
  input logic [DIV_W-1:0] div_n,
  input logic             clean_out,
  input logic             rate_tick,
  input logic             flip
);
  // R1: output held at idle level while reset is asserted
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> !clean_out);

  // R3: a qualifying flip event changes the output on the next cycle
  p_flip_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (clean_out != $past(clean_out)));

  // R4: fast rate selected means a tick on every cycle
  p_fast_every_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_out == swap_rates) |-> rate_tick);

  // R5: slow ticks never fall on back-to-back cycles when N >= 2
  p_slow_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_out != swap_rates && div_n >= 2 && rate_tick && !flip)
      |=> (!rate_tick || !$stable(div_n) || !$stable(swap_rates)));

  // R7: entering the slow rate gives no tick in the first cycle
  p_restart_divider_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && clean_out == swap_rates && div_n >= 2)
      |=> (!rate_tick || !$stable(div_n) || !$stable(swap_rates)));

  // R8: the output only moves after a cycle that carried a tick
  p_out_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_out != $past(clean_out)) |-> $past(rate_tick));
endmodule

bind asym_debounce asym_debounce_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .swap_rates(swap_rates), .div_n(div_n),
  .clean_out(clean_out), .rate_tick(rate_tick), .flip(flip_ev)
);

// File: tb/asym_debounce_test.sv
module asym_debounce_test;
  localparam int DIV_W = 8;
  localparam int SYNC  = 2;
  localparam int QUAL  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_in = 1'b0;
  logic swap_rates = 1'b0;
  logic [DIV_W-1:0] div_n = 8'd8;
  logic clean_out, rate_tick;

  asym_debounce #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC), .SAMPLES(QUAL)) uut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .div_n(div_n),
    .swap_rates(swap_rates), .clean_out(clean_out), .rate_tick(rate_tick)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: queue for the synchronizer, integers for the
  // output level, the length of the disagreeing run and slow-rate elapsed time.
  int mq[$] = '{0, 0};
  int m_out = 0;
  int m_run = 0;
  int m_since = 0;

  function automatic int m_slow();
    return (m_out != int'(swap_rates)) ? 1 : 0;
  endfunction

  function automatic int m_tick();
    if (m_slow() == 0) return 1;
    if (int'(div_n) <= 1) return 1;
    return (m_since >= int'(div_n) - 1) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq = '{0, 0};
      m_out = 0; m_run = 0; m_since = 0;
    end else begin
      int tk, sl, smp, done;
      tk = m_tick();
      sl = m_slow();
      smp = mq[0];
      void'(mq.pop_front());
      mq.push_back(int'(raw_in));
      done = 0;
      if (tk == 1) begin
        if (smp == m_out) m_run = 0;
        else if (m_run + 1 == QUAL) begin done = 1; m_run = 0; end
        else m_run++;
      end
      if (sl == 0 || done == 1 || tk == 1) m_since = 0;
      else m_since++;
      if (done == 1) m_out = 1 - m_out;
    end
    #2;
    if (rst_n) begin
      check("R3 clean_out vs model", int'(clean_out), m_out);
      check("R8 rate_tick vs model", int'(rate_tick), m_tick());
    end
  end

  task automatic wait_flip(output int k);
    logic start;
    start = clean_out;
    k = 0;
    while (clean_out == start && k < 1000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int k;
    idle(3);
    check("R1 clean_out in reset", int'(clean_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 clean_out after reset", int'(clean_out), 0);
    check("R6 fast tick while low", int'(rate_tick), 1);

    // R3: three-sample pulse must not qualify
    raw_in = 1'b1; idle(3); raw_in = 1'b0; idle(20);
    check("R3 short pulse rejected", int'(clean_out), 0);

    // R2/R4: fast attack latency
    raw_in = 1'b1; wait_flip(k);
    check("R2 fast attack edges", k, SYNC + QUAL);
    // R7: slow release right after flip takes 4N
    raw_in = 1'b0; wait_flip(k);
    check("R7 slow release edges", k, QUAL * 8);

    // Attack again, then tick spacing and a glitch between ticks
    idle(10);
    raw_in = 1'b1; wait_flip(k);
    check("R2 second attack edges", k, SYNC + QUAL);
    check("R6 no tick first slow cycle", int'(rate_tick), 0);
    raw_in = 1'b0;
    k = 0;
    while (!rate_tick && k < 100) begin
      @(negedge clk); k++;
      if (k == 2) raw_in = 1'b1;
    end
    check("R7 first slow tick", k, 7);
    k = 0;
    do begin @(negedge clk); k++; end while (!rate_tick && k < 100);
    check("R5 slow tick period", k, 8);
    check("R3 glitch between ticks ignored", int'(clean_out), 1);
    raw_in = 1'b0; wait_flip(k);
    check("R5 release completes", int'(k < 1000), 1);

    // R5: no division for N = 1 and N = 0
    idle(10);
    div_n = 8'd1;
    raw_in = 1'b1; wait_flip(k);
    check("R4 attack N=1", k, SYNC + QUAL);
    raw_in = 1'b0; wait_flip(k);
    check("R5 release N=1", k, SYNC + QUAL);
    div_n = 8'd0;
    raw_in = 1'b1; wait_flip(k);
    check("R4 attack N=0", k, SYNC + QUAL);
    raw_in = 1'b0; wait_flip(k);
    check("R5 release N=0", k, SYNC + QUAL);

    // R6: swapped rates, slow attack with N = 4, fast release
    idle(10);
    div_n = 8'd4; swap_rates = 1'b1; raw_in = 1'b1;
    wait_flip(k);
    check("R6 slow attack swapped", k, QUAL * 4);
    raw_in = 1'b0; wait_flip(k);
    check("R6 fast release swapped", k, SYNC + QUAL);

    // R1: reset in the middle of a run clears the partial count
    idle(10);
    swap_rates = 1'b0; div_n = 8'd8;
    raw_in = 1'b1; wait_flip(k);
    raw_in = 1'b0; idle(3);
    rst_n = 1'b0; #1;
    check("R1 async clear", int'(clean_out), 0);
    raw_in = 1'b1; idle(3);
    rst_n = 1'b1;
    wait_flip(k);
    check("R1 run restarted after reset", k, SYNC + QUAL);
    raw_in = 1'b0; wait_flip(k);

    // Random bounce, both modes, compared to the model every cycle
    for (int seg = 0; seg < 2; seg++) begin
      swap_rates = seg[0];
      div_n = (seg == 0) ? 8'd3 : 8'd5;
      idle(5);
      for (int b = 0; b < 300; b++) begin
        raw_in = ~raw_in;
        idle($urandom_range(1, ($urandom_range(0, 3) == 0) ? 40 : 4));
      end
    end

    idle(50);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule